// File: doc/BRIEF.md
# Register Window Call/Return Controller

This block is the control half of a windowed register file. It owns the current window pointer, a 13-bit status word (which also holds the saved window pointer and a system-mode bit), and a one-deep pending write for that status word. Every cycle it takes one request opcode together with operands computed elsewhere: the current PC, the last PC, the register-plus-operand sum and a 19-bit relative immediate. From these it produces the next PC, the window to read sources from, the window to write the destination in, the link value with its write enable, and a trap indication with its cause.

Calls rotate the window down by one, modulo 8. Returns rotate it up by one, modulo 8. A call that would land on the saved window traps instead. Relative jumps to an odd address are aborted to a fixed vector. Privileged requests made outside system mode are refused with their own trap. The register storage, the ALU and memory sit outside the block. The request outputs are combinational from the request and the held state, and the state advances at the clock edge that ends the request's cycle.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the current window is 0, no trap is raised, and a status read returns 0xFFFFE480: saved window 1 in status bits 12:10 and system mode in status bit 7.
- R2: An untrapped call (op 1 register, op 2 relative, op 3 interrupt) lowers the current window by one modulo 8 at the end of its cycle. A return (op 4) or interrupt return (op 5) with cond_i high raises it by one modulo 8 and sets next_pc to src_sum_i. With cond_i low, a return changes nothing and next_pc is cur_pc_i + 4.
- R3: A call whose lowered window equals the saved window raises trap with cause 1 and next_pc 0x80000020, writes no link, and leaves the window unchanged.
- R4: src_win_o always equals the current (old) window. dst_win_o is the current window minus one for the three call ops and the current window otherwise.
- R5: An untrapped interrupt call writes last_pc_i as the link. Register and relative calls write cur_pc_i.
- R6: A register call targets src_sum_i. A relative call targets cur_pc_i plus the sign-extended 19-bit immediate. Any request that neither branches nor traps gives next_pc = cur_pc_i + 4.
- R7: A relative jump (op 9) with cond_i low gives cur_pc_i + 4. With cond_i high it computes cur_pc_i plus the sign-extended immediate. If bit 0 of that target is 1, it instead raises trap cause 2 with next_pc 0x80000000.
- R8: A status write (op 6) stores src_sum_i bits 12:0. The value is not yet in effect in the cycle right after the write and is in effect from the cycle after that.
- R9: A status read (op 7) writes a link of all ones in bits 31:13 and the effective status word in bits 12:0.
- R10: Ops 3, 5, 6 and the last-PC read (op 8) are privileged. When status bit 7 is clear they raise trap cause 3 with next_pc 0x80000010, write no link, leave the window unchanged, and a refused status write has no effect.
- R11: An allowed last-PC read (op 8) writes last_pc_i as the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Request opcode (0 none, 1..9 as in the requirements) |
| cur_pc_i | input | 32 | PC of the current request |
| last_pc_i | input | 32 | Previous PC value |
| src_sum_i | input | 32 | Source register plus second operand |
| rel_imm_i | input | 19 | Relative immediate, signed |
| cond_i | input | 1 | Evaluated branch condition |
| next_pc_o | output | 32 | PC to fetch next |
| trap_o | output | 1 | Request trapped |
| trap_cause_o | output | 2 | 0 none, 1 window overflow, 2 misaligned jump, 3 privilege |
| src_win_o | output | 3 | Window for source reads |
| dst_win_o | output | 3 | Window for destination write |
| link_we_o | output | 1 | Destination write enable |
| link_val_o | output | 32 | Value to write |
| cwp_o | output | 3 | Current window pointer |

## Verification
A wrong window pointer shows up in the cycle right after the faulty update, on cwp_o and src_win_o. A call sequence then traps one call early or late against the saved window. A wrong status word or pending-write stage shows up two cycles after a status write, as a wrong status read or as a privileged request that is allowed or refused wrongly. Status reads exactly one and exactly two cycles after a write tell an early commit apart from a late one.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_CALL_REG = 4'd1,
    OP_CALL_REL = 4'd2,
    OP_CALL_INT = 4'd3,
    OP_RET      = 4'd4,
    OP_RET_INT  = 4'd5,
    OP_PSW_WR   = 4'd6,
    OP_PSW_RD   = 4'd7,
    OP_LPC_RD   = 4'd8,
    OP_JMP_REL  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    TC_NONE   = 2'd0,
    TC_WINDOW = 2'd1,
    TC_ALIGN  = 2'd2,
    TC_PRIV   = 2'd3
  } cause_e;

  typedef struct packed {
    logic call;
    logic ret;
    logic jmp;
    logic psw_wr;
    logic psw_rd;
    logic lpc_rd;
    logic priv;
    logic link_last;
    logic tgt_rel;
  } dec_t;

endpackage

// File: rtl/rwin_decode.sv
module rwin_decode
  import rwin_pkg::*;
(
  input  logic [3:0] op_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o = '0;
    case (op_i)
      OP_CALL_REG: dec_o.call = 1'b1;
      OP_CALL_REL: begin
        dec_o.call    = 1'b1;
        dec_o.tgt_rel = 1'b1;
      end
      OP_CALL_INT: begin
        dec_o.call      = 1'b1;
        dec_o.priv      = 1'b1;
        dec_o.link_last = 1'b1;
      end
      OP_RET:      dec_o.ret = 1'b1;
      OP_RET_INT: begin
        dec_o.ret  = 1'b1;
        dec_o.priv = 1'b1;
      end
      OP_PSW_WR: begin
        dec_o.psw_wr = 1'b1;
        dec_o.priv   = 1'b1;
      end
      OP_PSW_RD:   dec_o.psw_rd = 1'b1;
      OP_LPC_RD: begin
        dec_o.lpc_rd = 1'b1;
        dec_o.priv   = 1'b1;
      end
      OP_JMP_REL: begin
        dec_o.jmp     = 1'b1;
        dec_o.tgt_rel = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr #(
  parameter int WB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_dn_i,
  input  logic          step_up_i,
  output logic [WB-1:0] cwp_o
);

  logic [WB-1:0] cwp_q;
  logic [WB-1:0] cwp_d;
  logic          cwp_en;

  always_comb begin
    cwp_en = step_dn_i | step_up_i;
    cwp_d  = cwp_q;
    if (step_dn_i)      cwp_d = cwp_q - WB'(1);
    else if (step_up_i) cwp_d = cwp_q + WB'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cwp_q <= '0;
    else if (cwp_en) cwp_q <= cwp_d;
  end

  assign cwp_o = cwp_q;

  assert_call_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn_i |=> cwp_q == $past(cwp_q) - WB'(1));

  assert_ret_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_i |=> cwp_q == $past(cwp_q) + WB'(1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_dn_i && !step_up_i) |=> $stable(cwp_q));

endmodule

// File: rtl/rwin_psw.sv
module rwin_psw #(
  parameter int            PW      = 13,
  parameter int            WB      = 3,
  parameter int            SWP_LSB = 10,
  parameter int            SYS_BIT = 7,
  parameter logic [PW-1:0] RST_VAL = 13'h0480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [PW-1:0] ld_val_i,
  output logic [PW-1:0] psw_o,
  output logic [WB-1:0] swp_o,
  output logic          sys_o
);

  logic          pend_v_q, pend_v_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          pend_en;
  logic [PW-1:0] psw_q, psw_d;
  logic          psw_en;

  always_comb begin
    pend_v_d = ld_i;
    pend_en  = ld_i;
    pend_d   = ld_val_i;
    psw_en   = pend_v_q;
    psw_d    = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      psw_q    <= RST_VAL;
    end else begin
      pend_v_q <= pend_v_d;
      if (pend_en) pend_q <= pend_d;
      if (psw_en)  psw_q  <= psw_d;
    end
  end

  assign psw_o = psw_q;
  assign swp_o = psw_q[SWP_LSB +: WB];
  assign sys_o = psw_q[SYS_BIT];

  assert_psw_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !pend_v_q) |=> $stable(psw_q));

  assert_psw_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |=> psw_q == $past(pend_q));

endmodule

// File: rtl/rwin_flow.sv
module rwin_flow
  import rwin_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter int               WB        = 3,
  parameter int               PW        = 13,
  parameter int               IW        = 19,
  parameter int               PC_STEP   = 4,
  parameter logic [XLEN-1:0]  VEC_WIN   = 32'h8000_0020,
  parameter logic [XLEN-1:0]  VEC_ALIGN = 32'h8000_0000,
  parameter logic [XLEN-1:0]  VEC_PRIV  = 32'h8000_0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dec_t            dec_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] last_pc_i,
  input  logic [XLEN-1:0] src_sum_i,
  input  logic [IW-1:0]   rel_imm_i,
  input  logic            cond_i,
  input  logic [WB-1:0]   cwp_i,
  input  logic [WB-1:0]   swp_i,
  input  logic            sys_i,
  input  logic [PW-1:0]   psw_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            trap_o,
  output cause_e          cause_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o,
  output logic [WB-1:0]   dst_win_o,
  output logic            step_dn_o,
  output logic            step_up_o,
  output logic            psw_ld_o
);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_tgt;
  logic [WB-1:0]   win_down;
  logic            priv_bad;
  logic            win_hit;

  always_comb begin
    seq_pc   = cur_pc_i + XLEN'(PC_STEP);
    rel_tgt  = cur_pc_i + {{(XLEN-IW){rel_imm_i[IW-1]}}, rel_imm_i};
    win_down = cwp_i - WB'(1);
    priv_bad = dec_i.priv && !sys_i;
    win_hit  = dec_i.call && (win_down == swp_i);

    next_pc_o  = seq_pc;
    trap_o     = 1'b0;
    cause_o    = TC_NONE;
    link_we_o  = 1'b0;
    link_val_o = '0;
    step_dn_o  = 1'b0;
    step_up_o  = 1'b0;
    psw_ld_o   = 1'b0;
    dst_win_o  = dec_i.call ? win_down : cwp_i;

    if (priv_bad) begin
      trap_o    = 1'b1;
      cause_o   = TC_PRIV;
      next_pc_o = VEC_PRIV;
    end else if (dec_i.call) begin
      if (win_hit) begin
        trap_o    = 1'b1;
        cause_o   = TC_WINDOW;
        next_pc_o = VEC_WIN;
      end else begin
        step_dn_o  = 1'b1;
        link_we_o  = 1'b1;
        link_val_o = dec_i.link_last ? last_pc_i : cur_pc_i;
        next_pc_o  = dec_i.tgt_rel ? rel_tgt : src_sum_i;
      end
    end else if (dec_i.ret) begin
      if (cond_i) begin
        step_up_o = 1'b1;
        next_pc_o = src_sum_i;
      end
    end else if (dec_i.jmp) begin
      if (cond_i) begin
        if (rel_tgt[0]) begin
          trap_o    = 1'b1;
          cause_o   = TC_ALIGN;
          next_pc_o = VEC_ALIGN;
        end else begin
          next_pc_o = rel_tgt;
        end
      end
    end else if (dec_i.psw_wr) begin
      psw_ld_o = 1'b1;
    end else if (dec_i.psw_rd) begin
      link_we_o  = 1'b1;
      link_val_o = {{(XLEN-PW){1'b1}}, psw_i};
    end else if (dec_i.lpc_rd) begin
      link_we_o  = 1'b1;
      link_val_o = last_pc_i;
    end
  end

  assert_trap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (!link_we_o && !step_dn_o && !step_up_o && !psw_ld_o));

  assert_align_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && cause_o == TC_ALIGN) |-> (next_pc_o == VEC_ALIGN && dec_i.jmp && cond_i));

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int  XLEN    = 32,
  parameter int  WB      = 3,
  parameter int  PW      = 13,
  parameter int  IW      = 19,
  parameter int  SWP_LSB = 10,
  parameter int  SYS_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] last_pc_i,
  input  logic [XLEN-1:0] src_sum_i,
  input  logic [IW-1:0]   rel_imm_i,
  input  logic            cond_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            trap_o,
  output logic [1:0]      trap_cause_o,
  output logic [WB-1:0]   src_win_o,
  output logic [WB-1:0]   dst_win_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o,
  output logic [WB-1:0]   cwp_o
);

  localparam logic [PW-1:0] RST_PSW = PW'((1 << SWP_LSB) | (1 << SYS_BIT));

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dec_t          dec;
  logic [WB-1:0] cwp;
  logic [WB-1:0] swp;
  logic          sys;
  logic [PW-1:0] psw;
  logic          step_dn, step_up, psw_ld;
  cause_e        cause;

  rwin_decode u_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  rwin_ptr #(.WB(WB)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step_dn_i (step_dn),
    .step_up_i (step_up),
    .cwp_o     (cwp)
  );

  rwin_psw #(
    .PW(PW), .WB(WB), .SWP_LSB(SWP_LSB), .SYS_BIT(SYS_BIT), .RST_VAL(RST_PSW)
  ) u_psw (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld_i     (psw_ld),
    .ld_val_i (src_sum_i[PW-1:0]),
    .psw_o    (psw),
    .swp_o    (swp),
    .sys_o    (sys)
  );

  rwin_flow #(
    .XLEN(XLEN), .WB(WB), .PW(PW), .IW(IW)
  ) u_flow (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .dec_i      (dec),
    .cur_pc_i   (cur_pc_i),
    .last_pc_i  (last_pc_i),
    .src_sum_i  (src_sum_i),
    .rel_imm_i  (rel_imm_i),
    .cond_i     (cond_i),
    .cwp_i      (cwp),
    .swp_i      (swp),
    .sys_i      (sys),
    .psw_i      (psw),
    .next_pc_o  (next_pc_o),
    .trap_o     (trap_o),
    .cause_o    (cause),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o),
    .dst_win_o  (dst_win_o),
    .step_dn_o  (step_dn),
    .step_up_o  (step_up),
    .psw_ld_o   (psw_ld)
  );

  assign trap_cause_o = cause;
  assign src_win_o    = cwp;
  assign cwp_o        = cwp;

  assert_priv_trap_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dec.priv && !sys) |-> (trap_o && cause == TC_PRIV));

  assert_win_split_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_dn |-> (src_win_o != dst_win_o));

  assert_trap_freeze_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    trap_o |=> $stable(cwp));

endmodule

// File: tb/rwin_ctrl_tb_top.sv
module rwin_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] C_NOP = 4'd0, C_CREG = 4'd1, C_CREL = 4'd2, C_CINT = 4'd3,
                         C_RET = 4'd4, C_RETI = 4'd5, C_PWR = 4'd6, C_PRD = 4'd7,
                         C_LPC = 4'd8, C_JMP = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] cur_pc, last_pc, src_sum;
  logic [18:0] rel_imm;
  logic        cond;
  logic [31:0] next_pc, link_val;
  logic        trap, link_we;
  logic [1:0]  cause;
  logic [2:0]  src_win, dst_win, cwp;

  rwin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .cur_pc_i(cur_pc), .last_pc_i(last_pc),
    .src_sum_i(src_sum), .rel_imm_i(rel_imm), .cond_i(cond),
    .next_pc_o(next_pc), .trap_o(trap), .trap_cause_o(cause),
    .src_win_o(src_win), .dst_win_o(dst_win), .link_we_o(link_we),
    .link_val_o(link_val), .cwp_o(cwp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] npc;
    logic        trap;
    logic [1:0]  cause;
    logic        we;
    logic [31:0] link;
    logic [2:0]  src;
    logic [2:0]  dst;
    logic [2:0]  cwp;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // reference state
  logic [2:0]  m_cwp;
  logic [12:0] m_psw;
  logic        m_pend_v;
  logic [12:0] m_pend;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] pc, input logic [31:0] lpc,
                       input logic [31:0] sum, input logic [18:0] imm, input logic c,
                       input string tag);
    exp_t        e;
    logic [31:0] seq, rel;
    logic [2:0]  dn, nc;
    logic        is_call, is_priv, ld;
    @(negedge clk);
    op = o; cur_pc = pc; last_pc = lpc; src_sum = sum; rel_imm = imm; cond = c;
    seq     = pc + 32'd4;
    rel     = pc + {{13{imm[18]}}, imm};
    dn      = m_cwp - 3'd1;
    is_call = (o == C_CREG) || (o == C_CREL) || (o == C_CINT);
    is_priv = (o == C_CINT) || (o == C_RETI) || (o == C_PWR) || (o == C_LPC);
    e.tag = tag; e.npc = seq; e.trap = 0; e.cause = 0; e.we = 0; e.link = 0;
    e.src = m_cwp; e.dst = is_call ? dn : m_cwp; e.cwp = m_cwp;
    nc = m_cwp; ld = 0;
    if (is_priv && !m_psw[7]) begin
      e.trap = 1; e.cause = 2'd3; e.npc = 32'h8000_0010;
    end else if (is_call) begin
      if (dn == m_psw[12:10]) begin
        e.trap = 1; e.cause = 2'd1; e.npc = 32'h8000_0020;
      end else begin
        nc = dn; e.we = 1;
        e.link = (o == C_CINT) ? lpc : pc;
        e.npc  = (o == C_CREL) ? rel : sum;
      end
    end else if (o == C_RET || o == C_RETI) begin
      if (c) begin nc = m_cwp + 3'd1; e.npc = sum; end
    end else if (o == C_JMP) begin
      if (c) begin
        if (rel[0]) begin e.trap = 1; e.cause = 2'd2; e.npc = 32'h8000_0000; end
        else e.npc = rel;
      end
    end else if (o == C_PWR) begin
      ld = 1;
    end else if (o == C_PRD) begin
      e.we = 1; e.link = {19'h7FFFF, m_psw};
    end else if (o == C_LPC) begin
      e.we = 1; e.link = lpc;
    end
    exp_q.push_back(e);
    m_cwp = nc;
    if (m_pend_v) m_psw = m_pend;
    m_pend_v = ld;
    if (ld) m_pend = sum[12:0];
  endtask

  // monitor: compare outputs a quarter period after each drive
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(e.tag, "next_pc", next_pc, e.npc);
        chk(e.tag, "trap", 32'(trap), 32'(e.trap));
        chk(e.tag, "cause", 32'(cause), 32'(e.cause));
        chk(e.tag, "link_we", 32'(link_we), 32'(e.we));
        if (e.we) chk(e.tag, "link_val", link_val, e.link);
        chk(e.tag, "src_win", 32'(src_win), 32'(e.src));
        chk(e.tag, "dst_win", 32'(dst_win), 32'(e.dst));
        chk(e.tag, "cwp", 32'(cwp), 32'(e.cwp));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op = C_NOP; cur_pc = 0; last_pc = 0; src_sum = 0; rel_imm = 0; cond = 0;
    m_cwp = 3'd0; m_psw = 13'h0480; m_pend_v = 0; m_pend = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    issue(C_NOP, 32'h100, 0, 0, 0, 0, "R1 reset state");
    issue(C_PRD, 32'h104, 0, 0, 0, 0, "R1 R9 reset status read");
    issue(C_LPC, 32'h108, 32'hCAFE_0000, 0, 0, 0, "R11 last pc read");
    issue(C_CREG, 32'h100, 32'h0FC, 32'h400, 0, 0, "R6 R5 R4 register call");
    issue(C_CREL, 32'h400, 32'h100, 0, 19'h7FFF0, 0, "R6 R2 relative call backward");
    issue(C_CINT, 32'h3F0, 32'h1230, 32'h2000, 0, 0, "R5 interrupt call link");
    for (int i = 0; i < 3; i++) issue(C_CREG, 32'h2000, 0, 32'h3000, 0, 0, "R2 call chain");
    issue(C_CREG, 32'h3000, 0, 32'h4000, 0, 0, "R3 window overflow");
    issue(C_NOP, 32'h3004, 0, 0, 0, 0, "R3 window held");
    issue(C_RET, 32'h3008, 0, 32'h508, 0, 0, "R2 return not taken");
    issue(C_RET, 32'h300C, 0, 32'h508, 0, 1, "R2 return taken");
    issue(C_RETI, 32'h508, 0, 32'h600, 0, 1, "R2 interrupt return");
    issue(C_JMP, 32'h1000, 0, 0, 19'h00040, 0, "R7 jump not taken");
    issue(C_JMP, 32'h1000, 0, 0, 19'h00040, 1, "R7 jump taken");
    issue(C_JMP, 32'h1000, 0, 0, 19'h7FFFC, 1, "R7 jump backward");
    issue(C_JMP, 32'h1000, 0, 0, 19'h00041, 1, "R7 misaligned jump");
    issue(C_PWR, 32'h1004, 0, 32'hFFFF_FC80, 0, 0, "R8 status write");
    issue(C_PRD, 32'h1008, 0, 0, 0, 0, "R8 old status in next cycle");
    issue(C_PRD, 32'h100C, 0, 0, 0, 0, "R8 new status two cycles on");
    for (int i = 0; i < 5; i++) issue(C_CREL, 32'h2000, 0, 0, 19'h00100, 0, "R3 overflow at new saved window");
    issue(C_PWR, 32'h2100, 0, 32'h0000_0400, 0, 0, "R8 leave system mode");
    issue(C_NOP, 32'h2104, 0, 0, 0, 0, "R6 idle step");
    issue(C_NOP, 32'h2108, 0, 0, 0, 0, "R6 idle step");
    issue(C_CINT, 32'h210C, 32'h2108, 32'h5000, 0, 0, "R10 privileged interrupt call");
    issue(C_RETI, 32'h2110, 0, 32'h5000, 0, 1, "R10 privileged interrupt return");
    issue(C_PWR, 32'h2114, 0, 32'h0000_1FFF, 0, 0, "R10 status write refused");
    issue(C_LPC, 32'h2118, 32'h7777, 0, 0, 0, "R10 last pc read refused");
    issue(C_NOP, 32'h211C, 0, 0, 0, 0, "R10 idle step");
    issue(C_NOP, 32'h2120, 0, 0, 0, 0, "R10 idle step");
    issue(C_PRD, 32'h2124, 0, 0, 0, 0, "R10 R9 status unchanged");
    issue(C_CREG, 32'h2128, 0, 32'h6000, 0, 0, "R2 user call allowed");
    issue(C_RET, 32'h6000, 0, 32'h2130, 0, 1, "R2 user return allowed");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule